// File: doc/BRIEF.md
# VPW Bus End-of-Frame and Idle Detector

This block watches a single-wire variable-pulse-width serial bus that rests at a passive level and is driven to an active level by any node. It measures how long the bus has stayed passive since the last active symbol ended. When the next passive-to-active edge arrives, it sorts the passive gap that came before into one of three kinds: an ordinary in-frame passive symbol, a valid end-of-frame, or a valid end-of-frame followed by a complete inter-frame separation. If no edge arrives before the separation threshold, it declares the bus idle.

A local transmitter raises a pending request and waits for a start pulse. Normally the pulse comes once the bus has been passive for the full separation time. A pending node may also start early: when another node begins a start-of-frame edge after a valid end-of-frame gap, the block starts the local transmitter on that same edge, so that both nodes enter arbitration together. The inputs are a bus level that is already synchronized, a one-microsecond tick and the pending request. Bit decoding, arbitration and CRC are handled elsewhere.

Top module: `vpw_eof_idle_det`

## Requirements
- R1: During reset and on the first cycle after it, every strobe, `bus_idle` and `tx_start` is 0.
- R2: A passive-to-active edge that ends a passive gap of fewer than EOF_MIN_US ticks pulses `inframe_stb` for one cycle. The pulse appears on the cycle after the edge.
- R3: A passive-to-active edge that ends a gap of at least EOF_MIN_US ticks but fewer than IFS_MIN_US ticks pulses `eof_stb` for one cycle. At most one of the three class strobes is high in any cycle.
- R4: A passive-to-active edge that ends a gap of IFS_MIN_US ticks or more pulses `eof_ifs_stb` for one cycle.
- R5: `bus_idle` rises one cycle after the passive count reaches IFS_MIN_US. The count saturates, so `bus_idle` stays high for as long as the bus stays passive. It falls on the cycle after the bus goes active.
- R6: While a request is pending, no `tx_start` occurs during a passive gap that is shorter than IFS_MIN_US ticks. Once `bus_idle` is high, `tx_start` pulses on the next cycle.
- R7: If a request is pending and a passive-to-active edge ends a gap of at least EOF_MIN_US ticks, `tx_start` pulses in the same cycle as the class strobe.
- R8: If a request is pending and an edge ends a gap shorter than EOF_MIN_US ticks, no `tx_start` follows.
- R9: After reset, `bus_idle` rises only after IFS_MIN_US ticks of passive level. Until the first active-to-passive edge has been seen, an edge arriving before that point raises no class strobe.
- R10: Ticks that arrive while the bus is active are not counted. The passive count restarts from zero at each active-to-passive edge.
- R11: `tx_start` pulses at most once for each assertion of `tx_pending`. A later edge or idle period does not pulse it again until `tx_pending` has gone low and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_active | input | 1 | Synchronized bus level, 1 = active, 0 = passive |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| tx_pending | input | 1 | Local transmitter has a message waiting |
| inframe_stb | output | 1 | Gap was an in-frame passive symbol |
| eof_stb | output | 1 | Gap was a valid end-of-frame |
| eof_ifs_stb | output | 1 | Gap was a valid end-of-frame plus separation |
| bus_idle | output | 1 | Level: bus passive for at least the separation time |
| tx_start | output | 1 | One-cycle pulse: local transmitter may start |

## Verification
The bench builds the block with EOF_MIN_US set to 28 and IFS_MIN_US set to 30, and it raises a tick every second clock. With these values every threshold edge can be reached within a few dozen ticks. The gaps of 27, 28, 29 and 30 ticks then land on either side of both boundaries, and a 100-tick gap drives the counter into saturation. The scaled thresholds keep the same 28 to 30 ratio as the defaults, so each classification window and the early-start path are exercised with the same relative spacing.

// File: rtl/vpw_eof_pkg.sv
// Package: shared types for the VPW end-of-frame / idle detector.
package vpw_eof_pkg;
    // Classification of the passive gap closed by a passive-to-active edge.
    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_INFRAME = 2'd1,
        CLS_EOF     = 2'd2,
        CLS_EOF_IFS = 2'd3
    } gap_class_e;
endpackage

// File: rtl/vpw_edge_det.sv
// Edge detector on the synchronized bus level.
// Assumes lvl is already synchronized to clk. Resets to the passive level.
module vpw_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    // Remember the previous bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/vpw_passive_timer.sv
// Counts microsecond ticks of passive bus level.
// It holds at zero while the bus is active, restarts at each active-to-passive
// edge and saturates at LIMIT. Assumes a tick lasts one cycle.
module vpw_passive_timer #(
    parameter int LIMIT = 300,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_act,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    // Saturating passive-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (bus_act || restart) cnt <= '0;
        else if (tick && cnt != LIM_C) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/vpw_gap_classifier.sv
// Sorts the passive gap closed by a passive-to-active edge and keeps bus-idle.
// A gap is classified only after an active-to-passive edge has been seen since
// reset, or once idle has been declared. Assumes EOF_MIN < IFS_MIN.
module vpw_gap_classifier
    import vpw_eof_pkg::*;
#(
    parameter int EOF_MIN = 280,
    parameter int IFS_MIN = 300,
    parameter int CNT_W   = $clog2(IFS_MIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_act,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] cnt,
    output gap_class_e       cls,
    output logic             idle,
    output logic             early_ok
);
    localparam logic [CNT_W-1:0] EOF_C = CNT_W'(EOF_MIN);
    localparam logic [CNT_W-1:0] IFS_C = CNT_W'(IFS_MIN);

    logic       armed_q;
    logic       valid_gap;
    gap_class_e cls_d;

    assign valid_gap = rise && (armed_q || idle);
    assign early_ok  = valid_gap && (cnt >= EOF_C);

    // Choose the class of the gap that ends on this edge.
    always_comb begin
        cls_d = CLS_NONE;
        if (valid_gap) begin
            if (cnt < EOF_C)      cls_d = CLS_INFRAME;
            else if (cnt < IFS_C) cls_d = CLS_EOF;
            else                  cls_d = CLS_EOF_IFS;
        end
    end

    // Register the class, the idle level and the armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls     <= CLS_NONE;
            idle    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            cls     <= cls_d;
            idle    <= !bus_act && (cnt >= IFS_C);
            armed_q <= armed_q | fall;
        end
    end
endmodule

// File: rtl/vpw_tx_gate.sv
// Grants one start pulse to a pending local transmitter. The pulse comes when
// the bus is idle, or at once on a start-of-frame edge that follows a valid
// end-of-frame gap. Re-arms only when the request drops.
module vpw_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_pend,
    input  logic idle,
    input  logic bus_act,
    input  logic early_ok,
    output logic tx_start
);
    logic granted_q;
    logic fire;

    assign fire = tx_pend && !granted_q && ((idle && !bus_act) || early_ok);

    // Issue the start pulse and remember it for this request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_start  <= 1'b0;
            granted_q <= 1'b0;
        end else begin
            tx_start  <= fire;
            granted_q <= tx_pend && (granted_q || fire);
        end
    end
endmodule

// File: rtl/vpw_eof_idle_det.sv
// Top: VPW bus end-of-frame and idle detector.
// Assumes bus_active is synchronized (1 = active level) and us_tick is a
// one-cycle pulse once per microsecond. Thresholds are counted in ticks.
module vpw_eof_idle_det
    import vpw_eof_pkg::*;
#(
    parameter int EOF_MIN_US = 280,
    parameter int IFS_MIN_US = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_active,
    input  logic us_tick,
    input  logic tx_pending,
    output logic inframe_stb,
    output logic eof_stb,
    output logic eof_ifs_stb,
    output logic bus_idle,
    output logic tx_start
);
    localparam int CNT_W = $clog2(IFS_MIN_US + 1);

    logic             rise, fall, early_ok;
    logic [CNT_W-1:0] cnt;
    gap_class_e       cls;

    vpw_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(bus_active), .rise(rise), .fall(fall)
    );

    vpw_passive_timer #(.LIMIT(IFS_MIN_US), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .bus_act(bus_active), .restart(fall),
        .tick(us_tick), .cnt(cnt)
    );

    vpw_gap_classifier #(.EOF_MIN(EOF_MIN_US), .IFS_MIN(IFS_MIN_US), .CNT_W(CNT_W)) u_cls (
        .clk(clk), .rst_n(rst_n), .bus_act(bus_active), .rise(rise), .fall(fall),
        .cnt(cnt), .cls(cls), .idle(bus_idle), .early_ok(early_ok)
    );

    vpw_tx_gate u_gate (
        .clk(clk), .rst_n(rst_n), .tx_pend(tx_pending), .idle(bus_idle),
        .bus_act(bus_active), .early_ok(early_ok), .tx_start(tx_start)
    );

    assign inframe_stb = (cls == CLS_INFRAME);
    assign eof_stb     = (cls == CLS_EOF);
    assign eof_ifs_stb = (cls == CLS_EOF_IFS);
endmodule

// File: rtl/vpw_eof_idle_det_chk.sv
// Checker for vpw_eof_idle_det: port-level temporal properties.
module vpw_eof_idle_det_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_active,
    input logic us_tick,
    input logic tx_pending,
    input logic inframe_stb,
    input logic eof_stb,
    input logic eof_ifs_stb,
    input logic bus_idle,
    input logic tx_start
);
    // At most one class strobe at a time.
    assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inframe_stb, eof_stb, eof_ifs_stb}));

    // A class strobe follows an edge to the active level.
    assert_inframe_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inframe_stb |-> $past(bus_active));

    assert_eof_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eof_stb |=> !eof_stb);

    assert_eof_ifs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eof_ifs_stb |=> !eof_ifs_stb);

    // Idle is declared only over a passive bus.
    assert_idle_passive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> !$past(bus_active));

    // Start only for a pending request.
    assert_start_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(tx_pending));

    // Start is a single-cycle pulse.
    assert_start_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
endmodule

bind vpw_eof_idle_det vpw_eof_idle_det_chk u_chk (.*);

// File: tb/vpw_eof_idle_det_tb.sv
module vpw_eof_idle_det_tb;
    localparam int CLK_PERIOD = 10;
    localparam int EOF_T = 28;
    localparam int IFS_T = 30;

    logic clk = 1'b0;
    logic rst_n, bus_active, us_tick, tx_pending;
    logic inframe_stb, eof_stb, eof_ifs_stb, bus_idle, tx_start;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpw_eof_idle_det #(.EOF_MIN_US(EOF_T), .IFS_MIN_US(IFS_T)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .us_tick(us_tick),
        .tx_pending(tx_pending), .inframe_stb(inframe_stb), .eof_stb(eof_stb),
        .eof_ifs_stb(eof_ifs_stb), .bus_idle(bus_idle), .tx_start(tx_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1; step();
            us_tick = 1'b0; step();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_active = 1'b0; us_tick = 1'b0; tx_pending = 1'b0;
        step(); step();
        rst_n = 1'b1; step();
    endtask

    function automatic int cls3();
        return {inframe_stb, eof_stb, eof_ifs_stb};
    endfunction

    // Active pulse, passive gap of n ticks, then a new edge; sample the class.
    task automatic gap_then_edge(input int n, input int exp_cls, input string tag);
        bus_active = 1'b1; step(); step();
        bus_active = 1'b0; step();
        ticks(n);
        bus_active = 1'b1; step();
        chk(tag, cls3(), exp_cls);
        step();
        chk({tag, " pulse end"}, cls3(), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; bus_active = 1'b0; us_tick = 1'b0; tx_pending = 1'b0;
        step();
        chk("R1 strobes in reset", cls3(), 0);
        chk("R1 idle in reset", bus_idle, 0);
        rst_n = 1'b1; step();
        chk("R1 start after reset", tx_start, 0);
        chk("R1 idle after reset", bus_idle, 0);
    endtask

    task automatic t_reset_idle();
        do_reset();
        ticks(IFS_T - 1);
        chk("R9 not idle before threshold", bus_idle, 0);
        bus_active = 1'b1; step();
        chk("R9 no class before first fall", cls3(), 0);
        do_reset();
        ticks(IFS_T);
        chk("R9 idle after threshold from reset", bus_idle, 1);
    endtask

    task automatic t_classes();
        do_reset();
        gap_then_edge(10, 3'b100, "R2 inframe gap 10");
        gap_then_edge(EOF_T - 1, 3'b100, "R2 inframe gap 27");
        gap_then_edge(EOF_T, 3'b010, "R3 eof gap 28");
        gap_then_edge(IFS_T - 1, 3'b010, "R3 eof gap 29");
        gap_then_edge(IFS_T, 3'b001, "R4 eof_ifs gap 30");
        gap_then_edge(100, 3'b001, "R4 eof_ifs gap 100");
    endtask

    task automatic t_idle();
        do_reset();
        bus_active = 1'b1; step();
        bus_active = 1'b0; step();
        ticks(IFS_T - 1);
        chk("R5 not idle at 29", bus_idle, 0);
        ticks(1);
        chk("R5 idle at 30", bus_idle, 1);
        ticks(80);
        chk("R5 idle held saturated", bus_idle, 1);
        bus_active = 1'b1; step();
        chk("R5 idle cleared by edge", bus_idle, 0);
    endtask

    task automatic t_active_ticks();
        do_reset();
        bus_active = 1'b1; step();
        ticks(50);
        bus_active = 1'b0; step();
        ticks(EOF_T - 1);
        bus_active = 1'b1; step();
        chk("R10 active ticks ignored", cls3(), 3'b100);
        bus_active = 1'b0; step();
        ticks(20);
        bus_active = 1'b1; step(); step();
        bus_active = 1'b0; step();
        ticks(EOF_T - 1);
        bus_active = 1'b1; step();
        chk("R10 count restarts on fall", cls3(), 3'b100);
    endtask

    task automatic t_tx_wait();
        int seen = 0;
        do_reset();
        bus_active = 1'b1; step();
        bus_active = 1'b0; tx_pending = 1'b1; step();
        for (int i = 0; i < IFS_T - 1; i++) begin
            ticks(1);
            seen += tx_start;
        end
        chk("R6 no start before separation", seen, 0);
        ticks(1);
        chk("R6 no start same cycle as idle", tx_start, 0);
        step();
        chk("R6 start after idle", tx_start, 1);
        step();
        chk("R11 start is one pulse", tx_start, 0);
        ticks(5);
        chk("R11 no repeat while pending", tx_start, 0);
        tx_pending = 1'b0; step();
        tx_pending = 1'b1; step();
        chk("R11 new request starts again", tx_start, 1);
        tx_pending = 1'b0; step();
    endtask

    task automatic t_tx_early();
        do_reset();
        bus_active = 1'b1; step();
        bus_active = 1'b0; tx_pending = 1'b1; step();
        ticks(EOF_T);
        chk("R7 no start before edge", tx_start, 0);
        bus_active = 1'b1; step();
        chk("R7 early start on foreign edge", tx_start, 1);
        chk("R7 eof strobe with start", eof_stb, 1);
        step();
        chk("R7 early start one pulse", tx_start, 0);
        bus_active = 1'b0; step();
        ticks(IFS_T + 2);
        step();
        chk("R11 no second start for same request", tx_start, 0);
        tx_pending = 1'b0; step();
    endtask

    task automatic t_tx_short();
        int seen = 0;
        do_reset();
        bus_active = 1'b1; step();
        bus_active = 1'b0; tx_pending = 1'b1; step();
        ticks(EOF_T - 1);
        bus_active = 1'b1; step();
        seen += tx_start;
        step();
        seen += tx_start;
        chk("R8 no start on short gap edge", seen, 0);
        tx_pending = 1'b0; step();
    endtask

    initial begin
        t_reset();
        t_reset_idle();
        t_classes();
        t_idle();
        t_active_ticks();
        t_tx_wait();
        t_tx_early();
        t_tx_short();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule